// File: doc/BRIEF.md
# Programmable Chip-Select Bank Controller

This block is one memory bank of a general-purpose chip-select machine, together with the timer that sets the length of its bus cycles. Software writes a base register and an option register. Each bus address is compared with the programmed base, but only in the bit positions that the mask enables. When the bank matches and a transfer starts, the block drives a chip-select. On reads it also drives an output-enable. It then counts the programmed wait states and returns a transfer acknowledge. As an alternative, it can pass an acknowledge from the addressed device through to the bus.

The base register holds five fields: the compared base address in bits [31:15], the port size in bits [11:10], the machine select in bits [7:6], write-protect in bit 1 and valid in bit 0. The option register holds three fields: the address mask in bits [31:15], the wait-state count in bits [7:4] and external-acknowledge select in bit 3. Out of reset the bank acts as a global boot chip-select. It is valid, its mask is all zero and its port is 8 bits wide. Boot code reprograms it afterwards.

The cycle timer is a four-state machine:
- IDLE: the only state that accepts a start.
- WAIT: counts down the wait states.
- TACK: one cycle that gives the internal acknowledge.
- XACK: waits for the external acknowledge input.

The transitions are:
- IDLE→WAIT when a start hits and the wait count is non-zero.
- IDLE→TACK when a start hits and the wait count is zero.
- IDLE→XACK when a start hits and external acknowledge is selected.
- WAIT→TACK when the count reaches its last clock.
- TACK→IDLE always.
- XACK→IDLE when the external acknowledge arrives.

Top module: `csel_bank`

## Requirements
- R1: After reset the bank is valid, the mask is zero and the port size reads 01 (8-bit). The wait count is RST_WS (default 3). Every address, read or write, hits and gets a chip-select.
- R2: While the valid bit (base bit 0) is clear, the match flag and the chip-select stay low and no acknowledge is given.
- R3: An address hits when `addr[31:15]` equals base bits [31:15] in every position where option bits [31:15] are 1. Positions with a 0 in the mask, and address bits [14:0], are not compared.
- R4: With internal acknowledge, a start sampled at clock edge 0 gives an acknowledge during cycle 1+W, where W is option bits [7:4]. So W=0 is a two-clock access.
- R5: With write-protect (base bit 1) set, a write is a miss: no match flag, no chip-select, no acknowledge. Reads still hit.
- R6: A machine-select field (base bits [7:6]) other than 00 disables the bank.
- R7: With option bit 3 set, the acknowledge output follows the external acknowledge input while the cycle is open. No internal acknowledge is produced, and the cycle ends on that input.
- R8: The output-enable is high only during read cycles, and only while the chip-select is high.
- R9: The acknowledge lasts one clock. The chip-select is high during the acknowledge cycle and low in the next one.
- R10: A start that arrives while a cycle is open is ignored. It neither shortens nor extends the cycle, and it opens no second cycle.
- R11: The port-size output shows base bits [11:10] (01 = 8-bit).
- R12: Writing 0x20000001 to the base register and 0x000F8100 to the option register gives a valid bank at base 0x20000000 with zero wait states. Address 0x20000000 completes a read in two clocks, and 0x20008000 misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Write strobe for the base register |
| opt_we_i | input | 1 | Write strobe for the option register |
| wdata_i | input | 32 | Register write data |
| addr_i | input | 32 | Bus address |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| start_i | input | 1 | Transfer start, one clock |
| ext_ack_i | input | 1 | Acknowledge from the device (external mode) |
| cs_o | output | 1 | Chip-select, active high |
| oe_o | output | 1 | Output-enable, active high |
| ack_o | output | 1 | Transfer acknowledge |
| hit_o | output | 1 | Combinational match flag for the current address and direction |
| psize_o | output | 2 | Configured port size |

## Verification
The match flag and the port size are combinational, so they are sampled one time unit after the inputs are driven on the falling edge. A register write appears at the next falling edge. The acknowledge is due exactly 1+W falling edges after the start, and each access task counts edges from the start to the first acknowledge and compares that count. The chip-select is checked in the acknowledge cycle and again one edge later. Misses and ignored starts are observed for several cycles to confirm that no chip-select or acknowledge appears.

// File: rtl/csel_pkg.sv
package csel_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_TACK = 2'd2,
        S_XACK = 2'd3
    } cyc_state_t;

    localparam int FLD_LO    = 15;
    localparam int B_VALID   = 0;
    localparam int B_WPROT   = 1;
    localparam int B_MSEL_LO = 6;
    localparam int B_PSZ_LO  = 10;
    localparam int O_XACK    = 3;
    localparam int O_WS_LO   = 4;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
#(
    parameter int AW     = 32,
    parameter int WS_W   = 4,
    parameter int RST_WS = 3,
    localparam int CW    = AW - FLD_LO
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            base_we_i,
    input  logic            opt_we_i,
    input  logic [AW-1:0]   wdata_i,
    output logic [CW-1:0]   base_o,
    output logic [CW-1:0]   mask_o,
    output logic            valid_o,
    output logic            wprot_o,
    output logic [1:0]      msel_o,
    output logic [1:0]      psize_o,
    output logic [WS_W-1:0] wait_o,
    output logic            xack_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            base_o  <= '0;
            valid_o <= 1'b1;
            wprot_o <= 1'b0;
            msel_o  <= 2'b00;
            psize_o <= 2'b01;
        end else if (base_we_i) begin
            base_o  <= wdata_i[AW-1:FLD_LO];
            valid_o <= wdata_i[B_VALID];
            wprot_o <= wdata_i[B_WPROT];
            msel_o  <= wdata_i[B_MSEL_LO +: 2];
            psize_o <= wdata_i[B_PSZ_LO +: 2];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_o <= '0;
            wait_o <= WS_W'(RST_WS);
            xack_o <= 1'b0;
        end else if (opt_we_i) begin
            mask_o <= wdata_i[AW-1:FLD_LO];
            wait_o <= wdata_i[O_WS_LO +: WS_W];
            xack_o <= wdata_i[O_XACK];
        end
    end

    logic unused_bits;
    assign unused_bits = ^{wdata_i[FLD_LO-1:B_PSZ_LO+2], wdata_i[B_PSZ_LO-1:B_MSEL_LO+2],
                           wdata_i[B_MSEL_LO-1:B_WPROT+1]};
endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
#(
    parameter int AW  = 32,
    localparam int CW = AW - FLD_LO
) (
    input  logic [CW-1:0] addr_hi_i,
    input  logic [CW-1:0] base_i,
    input  logic [CW-1:0] mask_i,
    input  logic          valid_i,
    input  logic          wprot_i,
    input  logic [1:0]    msel_i,
    input  logic          wr_i,
    output logic          hit_o
);
    logic [CW-1:0] diff;

    always_comb begin
        diff  = (addr_hi_i ^ base_i) & mask_i;
        hit_o = valid_i && (msel_i == 2'b00) && (diff == '0) && !(wprot_i && wr_i);
    end
endmodule

// File: rtl/csel_fsm.sv
module csel_fsm
    import csel_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            hit_i,
    input  logic            wr_i,
    input  logic [WS_W-1:0] wait_i,
    input  logic            xack_sel_i,
    input  logic            ext_ack_i,
    output logic            cs_o,
    output logic            oe_o,
    output logic            ack_o
);
    cyc_state_t      state_q, state_d;
    logic [WS_W-1:0] cnt_q, cnt_d;
    logic            rd_q, rd_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rd_q    <= rd_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rd_d    = rd_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i && hit_i) begin
                    rd_d = !wr_i;
                    if (xack_sel_i) begin
                        state_d = S_XACK;
                    end else if (wait_i == '0) begin
                        state_d = S_TACK;
                    end else begin
                        state_d = S_WAIT;
                        cnt_d   = wait_i;
                    end
                end
            end
            S_WAIT: begin
                if (cnt_q == WS_W'(1)) state_d = S_TACK;
                cnt_d = cnt_q - 1'b1;
            end
            S_TACK: state_d = S_IDLE;
            S_XACK: if (ext_ack_i) state_d = S_IDLE;
        endcase
    end

    always_comb begin
        cs_o  = (state_q != S_IDLE);
        oe_o  = cs_o && rd_q;
        ack_o = (state_q == S_TACK) || ((state_q == S_XACK) && ext_ack_i);
    end
endmodule

// File: rtl/csel_bank.sv
module csel_bank
    import csel_pkg::*;
#(
    parameter int AW     = 32,
    parameter int WS_W   = 4,
    parameter int RST_WS = 3,
    localparam int CW    = AW - FLD_LO
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          base_we_i,
    input  logic          opt_we_i,
    input  logic [AW-1:0] wdata_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          start_i,
    input  logic          ext_ack_i,
    output logic          cs_o,
    output logic          oe_o,
    output logic          ack_o,
    output logic          hit_o,
    output logic [1:0]    psize_o
);
    logic [CW-1:0]   base_f, mask_f;
    logic            valid_f, wprot_f, xack_f;
    logic [1:0]      msel_f;
    logic [WS_W-1:0] wait_f;

    csel_regs #(.AW(AW), .WS_W(WS_W), .RST_WS(RST_WS)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .base_we_i(base_we_i), .opt_we_i(opt_we_i),
        .wdata_i(wdata_i), .base_o(base_f), .mask_o(mask_f), .valid_o(valid_f),
        .wprot_o(wprot_f), .msel_o(msel_f), .psize_o(psize_o), .wait_o(wait_f),
        .xack_o(xack_f)
    );

    csel_match #(.AW(AW)) u_match (
        .addr_hi_i(addr_i[AW-1:FLD_LO]), .base_i(base_f), .mask_i(mask_f),
        .valid_i(valid_f), .wprot_i(wprot_f), .msel_i(msel_f), .wr_i(wr_i),
        .hit_o(hit_o)
    );

    csel_fsm #(.WS_W(WS_W)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .hit_i(hit_o), .wr_i(wr_i),
        .wait_i(wait_f), .xack_sel_i(xack_f), .ext_ack_i(ext_ack_i),
        .cs_o(cs_o), .oe_o(oe_o), .ack_o(ack_o)
    );

    logic unused_addr;
    assign unused_addr = ^addr_i[FLD_LO-1:0];
endmodule

// File: rtl/csel_bank_chk.sv
module csel_bank_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic hit_o,
    input logic cs_o,
    input logic oe_o,
    input logic ack_o
);
    a_r8_oe_within_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_o |-> cs_o);

    a_r9_cs_drops_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !cs_o);

    a_r9_ack_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> cs_o);

    // R2, R5, R6: a chip-select only opens after a start that matched
    a_r2_cs_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_o) |-> $past(start_i && hit_o));

    a_r10_cycle_held_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_o && !ack_o) |=> cs_o);
endmodule

bind csel_bank csel_bank_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .hit_o(hit_o),
    .cs_o(cs_o), .oe_o(oe_o), .ack_o(ack_o)
);

// File: tb/sim_csel_bank.sv
module sim_csel_bank;
    localparam int CLK_PERIOD = 10;
    localparam int RST_WS     = 3;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n, base_we, opt_we, wr, start, ext_ack;
    logic [31:0] wdata, addr;
    logic        cs, oe, ack, hit;
    logic [1:0]  psize;
    int total = 0;
    int bad   = 0;

    csel_bank #(.RST_WS(RST_WS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .base_we_i(base_we), .opt_we_i(opt_we),
        .wdata_i(wdata), .addr_i(addr), .wr_i(wr), .start_i(start),
        .ext_ack_i(ext_ack), .cs_o(cs), .oe_o(oe), .ack_o(ack), .hit_o(hit),
        .psize_o(psize)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_base(logic [31:0] v);
        @(negedge clk); base_we = 1'b1; wdata = v;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic wr_opt(logic [31:0] v);
        @(negedge clk); opt_we = 1'b1; wdata = v;
        @(negedge clk); opt_we = 1'b0;
    endtask

    // one start pulse; checks match, cycle length, oe and chip-select release
    task automatic access(string tag, logic [31:0] a, logic w, logic exp_hit, int ws);
        int n;
        @(negedge clk); addr = a; wr = w; start = 1'b1;
        #1 chk({tag, " hit"}, 32'(hit), 32'(exp_hit));
        @(negedge clk); start = 1'b0;
        if (exp_hit) begin
            n = 1;
            while (!ack && n < 40) begin
                @(negedge clk); n++;
            end
            chk({tag, " ack clock"}, 32'(n), 32'(ws + 1));
            chk({tag, " cs at ack"}, 32'(cs), 32'd1);
            chk({tag, " oe at ack"}, 32'(oe), 32'(!w));
            @(negedge clk);
            chk({tag, " cs after ack"}, 32'(cs), 32'd0);
            chk({tag, " ack one clock"}, 32'(ack), 32'd0);
        end else begin
            for (int i = 0; i < 4; i++) begin
                chk({tag, " no cs/ack on miss"}, 32'({cs, ack}), 32'd0);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        chk("R11 R1 reset port size", 32'(psize), 32'd1);
        access("R1 reset read", 32'h1234_5678, 1'b0, 1'b1, RST_WS);
        access("R1 reset write", 32'hFFFF_0000, 1'b1, 1'b1, RST_WS);
    endtask

    task automatic t_example();
        wr_base(32'h2000_0001);
        wr_opt(32'h000F_8100);
        chk("R12 port size", 32'(psize), 32'd0);
        access("R12 base read", 32'h2000_0000, 1'b0, 1'b1, 0);
        access("R12 outside", 32'h2000_8000, 1'b0, 1'b0, 0);
    endtask

    task automatic t_mask();
        wr_base(32'h4000_0001);
        wr_opt(32'hFFFF_8000);
        access("R3 low bits ignored", 32'h4000_7FFC, 1'b0, 1'b1, 0);
        access("R3 bit15 compared", 32'h4000_8000, 1'b0, 1'b0, 0);
        wr_opt(32'hFFFE_0020);
        access("R3 R4 masked bit15/16", 32'h4001_8000, 1'b1, 1'b1, 2);
        access("R3 bit17 compared", 32'h4002_0000, 1'b0, 1'b0, 0);
    endtask

    task automatic t_waits();
        wr_opt(32'hFFFF_8070);
        access("R4 seven waits", 32'h4000_0000, 1'b0, 1'b1, 7);
        wr_opt(32'hFFFF_80F0);
        access("R4 fifteen waits", 32'h4000_0010, 1'b1, 1'b1, 15);
    endtask

    task automatic t_gates();
        wr_opt(32'hFFFF_8000);
        wr_base(32'h4000_0000);
        access("R2 valid clear", 32'h4000_0000, 1'b0, 1'b0, 0);
        wr_base(32'h4000_0041);
        access("R6 msel 01", 32'h4000_0000, 1'b0, 1'b0, 0);
        wr_base(32'h4000_0003);
        access("R5 protected write", 32'h4000_0000, 1'b1, 1'b0, 0);
        access("R5 protected read", 32'h4000_0000, 1'b0, 1'b1, 0);
        wr_base(32'h4000_0C01);
        chk("R11 port size 11", 32'(psize), 32'd3);
    endtask

    task automatic t_busy();
        int n;
        wr_base(32'h4000_0001);
        wr_opt(32'hFFFF_8040);
        @(negedge clk); addr = 32'h4000_0000; wr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0; n = 1;
        @(negedge clk); n++; wr = 1'b1; start = 1'b1;
        @(negedge clk); n++; start = 1'b0;
        while (!ack && n < 40) begin
            @(negedge clk); n++;
        end
        chk("R10 ack clock unchanged", 32'(n), 32'd5);
        chk("R10 still a read", 32'(oe), 32'd1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R10 no second cycle", 32'({cs, ack}), 32'd0);
        end
    endtask

    task automatic t_ext();
        wr_opt(32'hFFFF_8008);
        @(negedge clk); addr = 32'h4000_0000; wr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk("R7 held open", 32'({cs, ack}), 32'b10);
            @(negedge clk);
        end
        ext_ack = 1'b1;
        #1 chk("R7 ack follows input", 32'(ack), 32'd1);
        chk("R8 oe on read", 32'(oe), 32'd1);
        @(negedge clk); ext_ack = 1'b0;
        chk("R7 R9 cycle closed", 32'(cs), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; base_we = 1'b0; opt_we = 1'b0; wr = 1'b0;
        start = 1'b0; ext_ack = 1'b0; wdata = '0; addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 idle after reset", 32'({cs, oe, ack}), 32'd0);
        t_reset();
        t_example();
        t_mask();
        t_waits();
        t_gates();
        t_busy();
        t_ext();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule